// File: doc/BRIEF.md
# Serial Byte Exchange Sequencer

This block turns a single host request into one complete byte exchange through a synchronous serial port's transmit and receive FIFOs. The host sends a request strobe with a byte. The sequencer holds its busy flag high while it works. It finishes with a one-cycle done strobe that carries the received byte and a two-bit status code. The serial clock and the shifting of bits on the wire are handled by other logic. This block only decides when to push to the TX FIFO and when to pop from the RX FIFO.

A transfer runs in this order. First it stalls, with no time limit, until the TX FIFO has room. Next it polls an active-low slave-ready line for a limited number of cycles. Then it pushes the byte with its bit order reversed, placed in the upper half of a 16-bit word. Last it polls the RX FIFO for a limited number of cycles and pops one word. The low byte of that word, bit-reversed, is returned to the host. If the slave never becomes ready, the transfer is abandoned and nothing is pushed. If the RX FIFO stays empty, the pop still happens and the status only carries a warning.

A separate acquire/release lock tracks ownership of the bus. An acquire while the bus is already held is refused.

Top module: `spi_xfer_seq`

## Requirements
- R1: After a synchronous active-high reset, busy, done, tx_push, rx_pop, acq_refused and lock_held are all 0.
- R2: An accepted request raises busy. A request that arrives while busy is high is ignored: it causes no extra push and no extra done.
- R3: Nothing is pushed while tx_not_full is 0. This wait has no limit.
- R4: Once TX room exists, slave_ready_n is sampled once per cycle for at most POLL_LIMIT cycles. A low level on the last allowed sample still counts as ready.
- R5: If slave_ready_n stays high for all POLL_LIMIT samples, the transfer ends with done_status 1 and no push.
- R6: A push happens only in the cycle after slave_ready_n was sampled low. tx_word[15:8] holds the request byte with its bit order reversed (bit i goes to bit 7-i), and tx_word[7:0] is 0.
- R7: After the push, rx_not_empty is sampled for at most POLL_LIMIT cycles. The first high sample leads to exactly one pop.
- R8: If the RX wait runs out, one pop is still made and done_status is 2. When the RX FIFO answers in time, done_status is 0.
- R9: done_byte is rx_word[7:0] bit-reversed, taken in the pop cycle. done is high in the cycle after the pop, and it pulses exactly once per transfer.
- R10: With no stalls, done is visible 6 clock edges after the edge that accepts the request.
- R11: acq_req sets lock_held. An acq_req while the lock is held produces a one-cycle acq_refused and leaves lock_held at 1. rel_req clears lock_held and takes priority over acq_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_byte | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| done_byte | output | 8 | Received byte, bit-reversed |
| done_status | output | 2 | 0 ok, 1 ready timeout, 2 RX warning |
| acq_req | input | 1 | Acquire the bus lock |
| rel_req | input | 1 | Release the bus lock |
| lock_held | output | 1 | Lock state |
| acq_refused | output | 1 | Acquire refused because the lock was held |
| tx_not_full | input | 1 | TX FIFO has room |
| tx_push | output | 1 | TX FIFO write strobe |
| tx_word | output | 16 | TX FIFO write data |
| rx_not_empty | input | 1 | RX FIFO holds data |
| rx_pop | output | 1 | RX FIFO read strobe |
| rx_word | input | 16 | RX FIFO read data |
| slave_ready_n | input | 1 | Active-low slave ready |

## Verification
Take the edge that accepts a request as edge 0. With no stall, tx_push is high after edge 2, rx_pop after edge 4 and done after edge 5, which makes 6 edges in all. Each cycle of TX stall, and each ready or RX sample that finds nothing, adds one edge. A ready timeout finishes after POLL_LIMIT+2 edges. An RX answer on the last allowed sample, and an RX timeout, both finish after POLL_LIMIT+5 edges.

The bench drives inputs and samples outputs on the falling edge. It counts the edges until done and compares that count with the figure it computes for each case. It counts pushes and pops inside the same window. Lock results are read half a cycle after the edge that acts on the request.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_WTX, S_WRDY, S_PUSH, S_WRX, S_POP
  } seq_state_t;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_RDY_TO = 2'd1;
  localparam logic [1:0] ST_RX_WRN = 2'd2;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int LIMIT = 400000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last_poll
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign last_poll = (cnt == LAST);
endmodule

// File: rtl/seq_bus_lock.sv
module seq_bus_lock (
  input  logic clk,
  input  logic rst,
  input  logic acq,
  input  logic rel,
  output logic held,
  output logic refused
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      refused <= 1'b0;
    end else begin
      refused <= 1'b0;
      if (rel) held <= 1'b0;
      else if (acq) begin
        if (held) refused <= 1'b1;
        else      held    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 400000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_byte,
  output logic              busy,
  output logic              done,
  output logic [7:0]        done_byte,
  output logic [1:0]        done_status,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              lock_held,
  output logic              acq_refused,
  input  logic              tx_not_full,
  output logic              tx_push,
  output logic [15:0]       tx_word,
  input  logic              rx_not_empty,
  output logic              rx_pop,
  input  logic [15:0]       rx_word,
  input  logic              slave_ready_n
);
  seq_state_t        state;
  logic [BYTE_W-1:0] byte_q;
  logic              warn_q;
  logic              last_poll;

  // named internal events
  logic accept, ready_seen, ready_abort, rx_seen, rx_expire;
  assign accept      = (state == S_IDLE) && req_valid;
  assign ready_seen  = (state == S_WRDY) && !slave_ready_n;
  assign ready_abort = (state == S_WRDY) && slave_ready_n && last_poll;
  assign rx_seen     = (state == S_WRX) && rx_not_empty;
  assign rx_expire   = (state == S_WRX) && !rx_not_empty && last_poll;

  seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst),
    .clr((state == S_WTX) || (state == S_PUSH)),
    .inc((state == S_WRDY) || (state == S_WRX)),
    .last_poll(last_poll)
  );

  seq_bus_lock u_lock (
    .clk(clk), .rst(rst), .acq(acq_req), .rel(rel_req),
    .held(lock_held), .refused(acq_refused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      byte_q      <= '0;
      warn_q      <= 1'b0;
      done        <= 1'b0;
      done_byte   <= '0;
      done_status <= ST_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          byte_q <= req_byte;
          state  <= S_WTX;
        end
        S_WTX: if (tx_not_full) state <= S_WRDY;
        S_WRDY: begin
          if (ready_seen) state <= S_PUSH;
          else if (ready_abort) begin
            done        <= 1'b1;
            done_status <= ST_RDY_TO;
            done_byte   <= '0;
            state       <= S_IDLE;
          end
        end
        S_PUSH: state <= S_WRX;
        S_WRX: begin
          if (rx_seen || rx_expire) begin
            warn_q <= rx_expire;
            state  <= S_POP;
          end
        end
        S_POP: begin
          done        <= 1'b1;
          done_byte   <= rev_byte(rx_word[BYTE_W-1:0]);
          done_status <= warn_q ? ST_RX_WRN : ST_OK;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign tx_push = (state == S_PUSH);
  assign tx_word = {rev_byte(byte_q), {BYTE_W{1'b0}}};
  assign rx_pop  = (state == S_POP);
endmodule

module spi_xfer_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [1:0]  done_status,
  input logic        tx_push,
  input logic [15:0] tx_word,
  input logic        rx_pop,
  input logic        slave_ready_n,
  input logic        lock_held,
  input logic        acq_refused
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  // R6
  push_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(!slave_ready_n));
  // R6
  push_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> (tx_word[7:0] == 8'h00));
  // R7
  single_push_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push);
  // R9
  pop_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> (done && done_status != 2'd1));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11
  refuse_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    acq_refused |-> (lock_held && $past(lock_held)));
endmodule

bind spi_xfer_seq spi_xfer_seq_chk u_chk (.*);

// File: tb/spi_xfer_seq_test.sv
module spi_xfer_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 8;
  localparam int NEVER = 1000;

  logic clk = 0, rst = 1;
  logic req_valid = 0; logic [7:0] req_byte = 0;
  logic busy, done; logic [7:0] done_byte; logic [1:0] done_status;
  logic acq_req = 0, rel_req = 0, lock_held, acq_refused;
  logic tx_not_full = 0, tx_push; logic [15:0] tx_word;
  logic rx_not_empty = 0, rx_pop; logic [15:0] rx_word = 0;
  logic slave_ready_n = 1;

  int checks = 0, fails = 0;
  int cyc = 0;

  spi_xfer_seq #(.POLL_LIMIT(LIM)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [7:0] mirror(input logic [7:0] v);
    logic [7:0] m = 0;
    for (int k = 0; k < 8; k++) if (v[k]) m = m | (8'h80 >> k);
    return m;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // delays: tx stall, ready-low start, rx-present start (in edges after accept)
  task automatic xfer(input logic [7:0] b, input int txd, input int rdd, input int rxd,
                      input logic [15:0] rxw, input bit poke,
                      input logic [1:0] exp_st, input int exp_lat, input int exp_push,
                      input string tag);
    int pushes = 0, pops = 0, lat = -1, dones = 0;
    logic [15:0] seen_word = 16'hxxxx;
    logic [7:0] got_byte = 0; logic [1:0] got_st = 0;
    req_byte = b; req_valid = 1; rx_word = rxw;
    tx_not_full = (txd == 0); slave_ready_n = !(rdd == 0); rx_not_empty = (rxd == 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      req_valid = (poke && k == 2);
      req_byte  = poke ? ~b : b;
      tx_not_full   = (k >= txd);
      slave_ready_n = !(k >= rdd);
      rx_not_empty  = (k >= rxd);
      if (tx_push) begin pushes++; seen_word = tx_word; end
      if (rx_pop) pops++;
      if (done) begin
        dones++;
        if (lat < 0) begin lat = k + 1; got_byte = done_byte; got_st = done_status; end
      end
    end
    req_valid = 0; tx_not_full = 0; slave_ready_n = 1; rx_not_empty = 0;
    chk({tag, " R10/R4 latency"}, lat, exp_lat);
    chk({tag, " R9 done count"}, dones, 1);
    chk({tag, " R5/R8 status"}, got_st, exp_st);
    chk({tag, " R2 push count"}, pushes, exp_push);
    if (exp_push == 1) begin
      chk({tag, " R6 tx word"}, seen_word, {mirror(b), 8'h00});
      chk({tag, " R7 pop count"}, pops, 1);
      chk({tag, " R9 rx byte"}, got_byte, mirror(rxw[7:0]));
    end else
      chk({tag, " R5 no pop"}, pops, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 push", tx_push, 0); chk("R1 pop", rx_pop, 0);
    chk("R1 lock", lock_held, 0); chk("R1 refused", acq_refused, 0);

    // R6 R9 R10: full byte sweep, no stalls
    for (int b = 0; b < 256; b++)
      xfer(8'(b), 0, 0, 0, {8'h5A, 8'(b) ^ 8'h3C}, 0, 2'd0, 6, 1, "sweep");

    // R3: TX stall
    xfer(8'hC1, 5, 0, 0, 16'h0081, 0, 2'd0, 11, 1, "R3 stall");
    // R2: request while busy is ignored
    xfer(8'h17, 0, 0, 0, 16'h00F0, 1, 2'd0, 6, 1, "R2 poke");
    // R4: ready low on last allowed sample
    xfer(8'h2B, 0, LIM, 0, 16'h0033, 0, 2'd0, LIM + 5, 1, "R4 last poll");
    // R5: ready never low
    xfer(8'h2B, 0, LIM + 1, 0, 16'h0033, 0, 2'd1, LIM + 2, 0, "R5 abort");
    // R7: RX answers on last allowed sample
    xfer(8'h6E, 0, 0, LIM + 2, 16'hFF0D, 0, 2'd0, LIM + 5, 1, "R7 rx last");
    // R8: RX never answers, still pops
    xfer(8'h6E, 0, 0, NEVER, 16'hFF0D, 0, 2'd2, LIM + 5, 1, "R8 rx warn");

    // R11 lock
    acq_req = 1; @(negedge clk); acq_req = 0;
    chk("R11 acquire", lock_held, 1); chk("R11 no refuse", acq_refused, 0);
    acq_req = 1; @(negedge clk); acq_req = 0;
    chk("R11 refused", acq_refused, 1); chk("R11 still held", lock_held, 1);
    @(negedge clk);
    chk("R11 refuse pulse", acq_refused, 0);
    acq_req = 1; rel_req = 1; @(negedge clk); acq_req = 0; rel_req = 0;
    chk("R11 release wins", lock_held, 0); chk("R11 no refuse on rel", acq_refused, 0);
    acq_req = 1; @(negedge clk); acq_req = 0;
    chk("R11 reacquire", lock_held, 1);
    // R1: reset releases lock
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk("R1 lock after reset", lock_held, 0);
    chk("R1 busy after reset", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule